// File: doc/BRIEF.md
# Cascadable Up/Down Counter

A synchronous, presettable counter, 8 bits wide by default. A two-bit mode input chooses one of four actions at each rising clock edge: clear, count down, parallel load or count up. Counting also needs two active-low enables. One is a local count enable. The other is a chain enable that also qualifies the active-low carry output, so identical stages can be joined into a wider counter with no extra gates.

The carry output goes low while the chain enable is low and the count sits at its terminal value. That value is all ones in count-up mode and zero in every other mode. To chain stages, wire each stage's carry to the chain enable of the next stage and drive every stage with the same mode. A parameter decides whether the local count enable also gates the carry. A second parameter decides whether clear mode zeroes the count at once or at the next edge.

Top module: `updn_cascade_counter`

## Requirements
- R1: While rst_ni is low the count is 0, and this takes effect without waiting for a clock edge.
- R2: Mode 2'b10 (load) makes count_o equal data_i after the next rising edge.
- R3: Mode 2'b11 (count up) with both enables low adds one at each rising edge, and 255 wraps to 0.
- R4: Mode 2'b01 (count down) with both enables low subtracts one at each rising edge, and 0 wraps to 255.
- R5: In either count mode, a high level on cnt_en_ni or chain_en_ni at the edge leaves count_o unchanged.
- R6: Mode 2'b00 (clear) gives a count of 0. With ASYNC_CLR=0 this happens at the next rising edge. With ASYNC_CLR=1 it happens at once, without a clock edge.
- R7: carry_no is low only while chain_en_ni is low and count_o equals the terminal value (255 in mode 2'b11, 0 in the other modes). With CARRY_GATED=1, a high cnt_en_ni also forces carry_no high. With CARRY_GATED=0, cnt_en_ni has no effect on carry_no.
- R8: With ASYNC_CLR=0, a change on mode_i between clock edges leaves count_o unchanged until the next rising edge.
- R9: Load and clear ignore both enables.
- R10: Two stages with the upper chain enable driven by the lower carry step through 0 to 65535 together, up and down, with no extra logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 clear, 01 down, 10 load, 11 up |
| cnt_en_ni | input | 1 | Local count enable, active low |
| chain_en_ni | input | 1 | Chain enable, active low; also qualifies the carry |
| data_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Current count |
| carry_no | output | 1 | Terminal-count carry, active low |

## Verification
The step and hold assertions assume that mode_i and both enables are stable at each rising edge. The bench meets this by changing inputs only at falling edges. In the asynchronous-clear variant, a clear that arrives in the middle of a cycle overrides the result of the previous edge, and the step assertions allow for that case explicitly. The mid-cycle checks change the mode or enables at a falling edge and sample before the next rising edge, so each change is seen in isolation. The two-stage chain is driven only through its ports.

// File: rtl/udc_pkg.sv
package udc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_DOWN  = 2'b01,
    MODE_LOAD  = 2'b10,
    MODE_UP    = 2'b11
  } udc_mode_e;
endpackage

// File: rtl/udc_next_value.sv
module udc_next_value
  import udc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  udc_mode_e          mode_i,
  input  logic               run_i,
  input  logic [WIDTH-1:0]   cur_i,
  input  logic [WIDTH-1:0]   data_i,
  output logic [WIDTH-1:0]   nxt_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: nxt_o = '0;
      MODE_LOAD:  nxt_o = data_i;
      MODE_UP:    nxt_o = run_i ? cur_i + ONE : cur_i;
      MODE_DOWN:  nxt_o = run_i ? cur_i - ONE : cur_i;
      default:    nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/udc_term_detect.sv
module udc_term_detect
  import udc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit CARRY_GATED = 1'b0
) (
  input  udc_mode_e        mode_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic             cnt_en_ni,
  input  logic             chain_en_ni,
  output logic             carry_no
);
  timeunit 1ns;
  timeprecision 1ps;

  logic at_term;
  logic qual;

  assign at_term = (mode_i == MODE_UP) ? (&cur_i) : ~(|cur_i);

  generate
    if (CARRY_GATED) begin : g_both
      assign qual = ~chain_en_ni & ~cnt_en_ni;
    end else begin : g_chain
      assign qual = ~chain_en_ni;
    end
  endgenerate

  assign carry_no = ~(qual & at_term);
endmodule

// File: rtl/udc_count_reg.sv
module udc_count_reg #(
  parameter int WIDTH     = 8,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  timeunit 1ns;
  timeprecision 1ps;

  generate
    if (ASYNC_CLR) begin : g_async
      logic arst_n;
      // clear mode acts as a second asynchronous reset
      assign arst_n = rst_ni & ~clr_i;
      always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) q_o <= '0;
        else         q_o <= nxt_i;
      end

      AST_CLEAR_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |-> (q_o == '0)); // R6
    end else begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= nxt_i;
      end

      AST_CLEAR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (q_o == '0)); // R6
    end
  endgenerate
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit CARRY_GATED = 1'b0,
  parameter bit ASYNC_CLR   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             cnt_en_ni,
  input  logic             chain_en_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_no
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  udc_mode_e        mode;
  logic             run;
  logic             clr;
  logic [WIDTH-1:0] nxt;

  assign mode = udc_mode_e'(mode_i);
  assign run  = ~cnt_en_ni & ~chain_en_ni;
  assign clr  = (mode == MODE_CLEAR);

  udc_next_value #(.WIDTH(WIDTH)) u_next (
    .mode_i (mode),
    .run_i  (run),
    .cur_i  (count_o),
    .data_i (data_i),
    .nxt_o  (nxt)
  );

  udc_count_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .nxt_i  (nxt),
    .q_o    (count_o)
  );

  udc_term_detect #(.WIDTH(WIDTH), .CARRY_GATED(CARRY_GATED)) u_term (
    .mode_i      (mode),
    .cur_i       (count_o),
    .cnt_en_ni   (cnt_en_ni),
    .chain_en_ni (chain_en_ni),
    .carry_no    (carry_no)
  );

  // async clear arriving mid-cycle overrides the previous edge result
  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |=> ((ASYNC_CLR && mode_i == 2'b00) || count_o == $past(data_i))); // R2
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !cnt_en_ni && !chain_en_ni)
      |=> ((ASYNC_CLR && mode_i == 2'b00) || count_o == $past(count_o) + ONE)); // R3
  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !cnt_en_ni && !chain_en_ni)
      |=> ((ASYNC_CLR && mode_i == 2'b00) || count_o == $past(count_o) - ONE)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] && (cnt_en_ni || chain_en_ni))
      |=> ((ASYNC_CLR && mode_i == 2'b00) || $stable(count_o))); // R5
  AST_CARRY_NEEDS_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> !chain_en_ni); // R7
  AST_CARRY_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (count_o == ((mode_i == 2'b11) ? {WIDTH{1'b1}} : {WIDTH{1'b0}}))); // R7
endmodule

// File: tb/updn_cascade_counter_test.sv
module updn_cascade_counter_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // single stage, sync clear, carry ungated by count enable
  logic [1:0] u_mode = 2'b10;
  logic       u_p = 1'b1, u_t = 1'b1;
  logic [7:0] u_data = 8'h00;
  logic [7:0] u_q;
  logic       u_c;
  updn_cascade_counter uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(u_mode), .cnt_en_ni(u_p),
    .chain_en_ni(u_t), .data_i(u_data), .count_o(u_q), .carry_no(u_c));

  // async clear, gated carry
  logic [1:0] a_mode = 2'b10;
  logic       a_p = 1'b1, a_t = 1'b1;
  logic [7:0] a_data = 8'hFF;
  logic [7:0] a_q;
  logic       a_c;
  updn_cascade_counter #(.CARRY_GATED(1'b1), .ASYNC_CLR(1'b1)) u_async (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(a_mode), .cnt_en_ni(a_p),
    .chain_en_ni(a_t), .data_i(a_data), .count_o(a_q), .carry_no(a_c));

  // two chained stages
  logic [1:0] c_mode = 2'b00;
  logic       c_p = 1'b0;
  logic [7:0] lo_q, hi_q;
  logic       lo_c, hi_c;
  updn_cascade_counter u_lo (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(c_mode), .cnt_en_ni(c_p),
    .chain_en_ni(1'b0), .data_i(8'h00), .count_o(lo_q), .carry_no(lo_c));
  updn_cascade_counter u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(c_mode), .cnt_en_ni(c_p),
    .chain_en_ni(lo_c), .data_i(8'h00), .count_o(hi_q), .carry_no(hi_c));

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] mode;
    logic       p;
    logic       t;
    logic [7:0] data;
    logic [7:0] q;
    logic       c;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd9, 2'b10, 1'b1, 1'b1, 8'hFE, 8'hFE, 1'b1}, // R9 load with enables off
    '{4'd3, 2'b11, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0}, // R3 up, terminal carry
    '{4'd3, 2'b11, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R3 wrap
    '{4'd4, 2'b01, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1}, // R4 wrap down
    '{4'd7, 2'b10, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R7 zero terminal in load mode
    '{4'd4, 2'b01, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b1}, // R4
    '{4'd5, 2'b01, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1}, // R5 hold
    '{4'd2, 2'b10, 1'b1, 1'b1, 8'h01, 8'h01, 1'b1}, // R2
    '{4'd5, 2'b01, 1'b0, 1'b1, 8'h00, 8'h01, 1'b1}, // R5 chain off
    '{4'd5, 2'b01, 1'b1, 1'b0, 8'h00, 8'h01, 1'b1}, // R5 count off
    '{4'd4, 2'b01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R4 down to terminal
    '{4'd7, 2'b01, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0}, // R7 ungated variant
    '{4'd2, 2'b10, 1'b0, 1'b0, 8'hAA, 8'hAA, 1'b1}, // R2
    '{4'd6, 2'b00, 1'b1, 1'b1, 8'h55, 8'h00, 1'b1}, // R6 sync clear, R9
    '{4'd3, 2'b11, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1}  // R3
  };

  initial begin
    int mism;
    #1;
    chk("R1 reset count", 32'(u_q), 32'h00);
    chk("R1 reset count async", 32'(a_q), 32'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      u_mode = VECS[i].mode; u_p = VECS[i].p; u_t = VECS[i].t; u_data = VECS[i].data;
      @(posedge clk);
      #1;
      chk($sformatf("R%0d table %0d count", VECS[i].req, i), 32'(u_q), 32'(VECS[i].q));
      chk($sformatf("R7 table %0d carry", i), 32'(u_c), 32'(VECS[i].c));
    end

    // R8: mode change mid-cycle has no effect before the edge
    @(negedge clk);
    u_mode = 2'b00;
    #1;
    chk("R8 clear pending", 32'(u_q), 32'h01);
    u_mode = 2'b10; u_data = 8'h5A; u_p = 1'b1;
    #0.5;
    chk("R8 load pending", 32'(u_q), 32'h01);
    @(posedge clk);
    #1;
    chk("R2 load after edge", 32'(u_q), 32'h5A);

    // async variant: loaded FF during the table
    chk("R2 async load", 32'(a_q), 32'hFF);
    @(negedge clk);
    a_mode = 2'b11; a_p = 1'b0; a_t = 1'b0;
    #1;
    chk("R7 carry at all ones", 32'(a_c), 32'h0);
    a_p = 1'b1;
    #0.5;
    chk("R7 gated carry", 32'(a_c), 32'h1);
    a_mode = 2'b00;
    #0.5;
    chk("R6 async clear immediate", 32'(a_q), 32'h00);
    @(negedge clk);
    a_mode = 2'b10; a_data = 8'h33;

    // R1: reset mid-run acts at once
    #1;
    rst_ni = 1'b0;
    #0.5;
    chk("R1 reset mid-run", 32'(u_q), 32'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    // R10: chained stages
    @(negedge clk);
    c_mode = 2'b00;
    @(negedge clk);
    c_mode = 2'b11;
    mism = 0;
    for (int i = 1; i <= 65536; i++) begin
      @(posedge clk);
      #1;
      if ({hi_q, lo_q} !== 16'(i)) begin
        if (mism == 0) $display("FAIL R10 up at %0d actual=%0h expected=%0h", i, {hi_q, lo_q}, 16'(i));
        mism++;
      end
      if (i == 65535) chk("R10 chain carry at top", 32'(hi_c), 32'h0);
    end
    total++;
    if (mism != 0) bad++;
    @(negedge clk);
    c_mode = 2'b01;
    mism = 0;
    for (int i = 1; i <= 65536; i++) begin
      @(posedge clk);
      #1;
      if ({hi_q, lo_q} !== 16'(-i)) begin
        if (mism == 0) $display("FAIL R10 down at %0d actual=%0h expected=%0h", i, {hi_q, lo_q}, 16'(-i));
        mism++;
      end
    end
    total++;
    if (mism != 0) bad++;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule